// File: doc/BRIEF.md
# Multiplierless Transposed FIR Filter

This block is a fixed-coefficient FIR filter in transposed direct form. Each accepted input sample goes to every coefficient product at once. The products come from one shared shift-add term network, so the design contains no hardware multiplier. Each product then enters a chain of adders and registers, with one register per tap. The coefficients are signed integers set by parameters.

The term network produces the magnitude product for each coefficient, together with a per-tap sign flag. When a tap's flag is set, the adder at that tap's position in the chain becomes a subtractor. No separate negation stage exists anywhere.

The filter is used by presenting a signed sample with a valid strobe. One clock later, a full-precision filtered result appears together with its own valid strobe.

Top module: `fir_tc_top`

## Requirements
- R1: When out_valid is high, y_o equals the sum over k of COEF[k]·x[n−k], where x[n] is the newest accepted sample and x[n−k] is the sample accepted k valid cycles earlier. Samples before the last reset count as zero. The result is exact two's complement.
- R2: Each coefficient product is formed only from shifted copies of the input, combined in an add/subtract tree of at most 3 operator levels. This holds for coefficient magnitudes below 2^(COEF_W−1), whose signed-digit form has no more than 8 nonzero digits. Every product equals the exact magnitude product.
- R3: A tap with a negative coefficient contributes its product through a subtraction in the register chain. The impulse response therefore reproduces each negative coefficient with its sign.
- R4: Cycles with in_valid low neither advance nor clear the chain. y_o holds its value, and no zero sample is inserted into the history.
- R5: out_valid is in_valid delayed by exactly one clock, and y_o updates in the same cycle that out_valid rises.
- R6: A synchronous active-high reset drives y_o to zero and out_valid low on the clock after it is sampled, and it clears all tap history.
- R7: The output width is DATA_W + COEF_W + clog2(N_TAPS). With this width, no stage overflows, even with full-scale alternating inputs of −2^(DATA_W−1) and 2^(DATA_W−1)−1.
- R8: The tap count is a parameter. Both a 4-tap and a 10-tap configuration meet R1 to R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe; advances the chain |
| x_i | input | DATA_W | Signed input sample |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| y_o | output | DATA_W+COEF_W+clog2(N_TAPS) | Signed filtered output |

## Verification
An impulse reads every coefficient out of the chain in order. This separates tap ordering errors and sign-flag errors, because a stage that adds where it should subtract flips one coefficient's sign. A constant step exposes the running coefficient sums. Alternating full-scale extremes push the chain towards its widest values, which exposes a truncated stage width. Random samples with idle gaps and a mid-stream reset, run in both the 4-tap and the 10-tap build, separate correct hold and clear behaviour from a chain that shifts on idle cycles or keeps stale history.

// File: rtl/fir_mcm_pkg.sv
package fir_mcm_pkg;

    // Depth of the per-coefficient add tree, and the term slots it offers
    localparam int TREE_LVLS = 3;
    localparam int MAX_TERMS = 2 ** TREE_LVLS;

    // Signed-digit recoding of a non-negative magnitude.
    // pick_minus = 0 returns the +1 digit positions, 1 returns the -1 positions.
    function automatic logic [31:0] sd_mask(input int mag, input bit pick_minus);
        int v;
        logic [31:0] m;
        v = mag;
        m = '0;
        for (int i = 0; i < 31; i++) begin
            if (v % 2 != 0) begin
                if (v % 4 == 1) begin
                    if (!pick_minus) m[i] = 1'b1;
                    v = v - 1;
                end else begin
                    if (pick_minus) m[i] = 1'b1;
                    v = v + 1;
                end
            end
            v = v / 2;
        end
        return m;
    endfunction

    function automatic int mag_of(input int a);
        return (a < 0) ? -a : a;
    endfunction

endpackage

// File: rtl/fir_shift_add_mult.sv
module fir_shift_add_mult
    import fir_mcm_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int COEF_W = 8,
    parameter int MAG    = 3,
    localparam int PROD_W = DATA_W + COEF_W + 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [DATA_W-1:0] x_i,
    output logic signed [PROD_W-1:0] prod_o
);

    localparam logic [31:0] PLUS_M  = sd_mask(MAG, 1'b0);
    localparam logic [31:0] MINUS_M = sd_mask(MAG, 1'b1);

    logic signed [PROD_W-1:0] x_ext;
    logic signed [PROD_W-1:0] term_d [MAX_TERMS];
    logic signed [PROD_W-1:0] lvl1_d [MAX_TERMS/2];
    logic signed [PROD_W-1:0] lvl2_d [MAX_TERMS/4];

    // Gather the signed shifted terms into fixed tree slots
    always_comb begin
        int idx;
        idx   = 0;
        x_ext = PROD_W'(x_i);
        for (int t = 0; t < MAX_TERMS; t++) term_d[t] = '0;
        for (int b = 0; b < COEF_W; b++) begin
            if (PLUS_M[b] || MINUS_M[b]) begin
                if (idx < MAX_TERMS) begin
                    term_d[idx] = PLUS_M[b] ? (x_ext <<< b) : -(x_ext <<< b);
                end
                idx = idx + 1;
            end
        end
    end

    // Three operator levels: 8 -> 4 -> 2 -> 1
    always_comb begin
        for (int i = 0; i < MAX_TERMS/2; i++) lvl1_d[i] = term_d[2*i] + term_d[2*i+1];
        for (int i = 0; i < MAX_TERMS/4; i++) lvl2_d[i] = lvl1_d[2*i] + lvl1_d[2*i+1];
        prod_o = lvl2_d[0] + lvl2_d[1];
    end

    AST_PROD_EXACT: assert property (@(posedge clk) disable iff (rst)
        int'(prod_o) == int'(x_i) * MAG); // R2

endmodule

// File: rtl/fir_term_net.sv
module fir_term_net
    import fir_mcm_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int COEF_W = 8,
    parameter int N_TAPS = 4,
    parameter int COEF [N_TAPS] = '{3, -5, 7, -2},
    localparam int PROD_W = DATA_W + COEF_W + 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic signed [DATA_W-1:0]      x_i,
    output logic [N_TAPS-1:0][PROD_W-1:0] prod_o,
    output logic [N_TAPS-1:0]             neg_o
);

    for (genvar k = 0; k < N_TAPS; k++) begin : g_tap
        logic signed [PROD_W-1:0] p_w;

        fir_shift_add_mult #(
            .DATA_W (DATA_W),
            .COEF_W (COEF_W),
            .MAG    (mag_of(COEF[k]))
        ) u_mult (
            .clk    (clk),
            .rst    (rst),
            .x_i    (x_i),
            .prod_o (p_w)
        );

        assign prod_o[k] = p_w;
        assign neg_o[k]  = (COEF[k] < 0);
    end

endmodule

// File: rtl/fir_tc_top.sv
module fir_tc_top
    import fir_mcm_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int COEF_W = 8,
    parameter int N_TAPS = 4,
    parameter int COEF [N_TAPS] = '{3, -5, 7, -2},
    localparam int OUT_W = DATA_W + COEF_W + $clog2(N_TAPS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] x_i,
    output logic                     out_valid,
    output logic signed [OUT_W-1:0]  y_o
);

    localparam int PROD_W = DATA_W + COEF_W + 1;

    typedef struct packed {
        logic                         vld;
        logic [N_TAPS-1:0][OUT_W-1:0] acc;
    } state_t;

    state_t s_d, s_q;

    logic [N_TAPS-1:0][PROD_W-1:0] prod_w;
    logic [N_TAPS-1:0]             neg_w;
    logic signed [OUT_W:0]         wide_d [N_TAPS];

    fir_term_net #(
        .DATA_W (DATA_W),
        .COEF_W (COEF_W),
        .N_TAPS (N_TAPS),
        .COEF   (COEF)
    ) u_terms (
        .clk    (clk),
        .rst    (rst),
        .x_i    (x_i),
        .prod_o (prod_w),
        .neg_o  (neg_w)
    );

    // Structural adder-register line; a set sign flag turns the stage into a subtractor
    always_comb begin
        logic signed [OUT_W:0] tail, pe;
        s_d     = s_q;
        s_d.vld = in_valid;
        for (int k = 0; k < N_TAPS; k++) begin
            tail = (k == N_TAPS - 1) ? '0 : (OUT_W+1)'($signed(s_q.acc[(k+1) % N_TAPS]));
            pe   = (OUT_W+1)'($signed(prod_w[k]));
            wide_d[k] = neg_w[k] ? (tail - pe) : (tail + pe);
            if (in_valid) s_d.acc[k] = wide_d[k][OUT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign out_valid = s_q.vld;
    assign y_o       = $signed(s_q.acc[0]);

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R5
    AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(y_o)); // R4

    for (genvar k = 0; k < N_TAPS; k++) begin : g_chk
        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
            in_valid |-> (wide_d[k][OUT_W] == wide_d[k][OUT_W-1])); // R7
    end

endmodule

// File: tb/tb_fir_tc_top.sv
module tb_fir_tc_top;

    localparam int DW = 8;
    localparam int CW = 8;
    localparam int N4 = 4;
    localparam int N10 = 10;
    localparam int C4 [N4]   = '{3, -5, 7, -2};
    localparam int C10 [N10] = '{1, -3, 5, 11, -23, 45, -77, 100, -127, 13};
    localparam int NSTIM = 32;
    // impulse, step, alternating full scale
    localparam int STIM [NSTIM] = '{1, 0, 0, 0, 0, 0, 0, 0, 0, 0,
                                    7, 7, 7, 7, 7, 7, 7, 7, 7, 7,
                                    127, -128, 127, -128, 127, -128,
                                    127, -128, 127, -128, 127, -128};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [DW-1:0] x_i = '0;
    logic v4, v10;
    logic signed [17:0] y4;
    logic signed [19:0] y10;

    int checks = 0;
    int errors = 0;
    int h4 [N4];
    int h10 [N10];
    int e4 = 0;
    int e10 = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fir_tc_top #(.DATA_W(DW), .COEF_W(CW), .N_TAPS(N4), .COEF(C4)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .x_i(x_i),
        .out_valid(v4), .y_o(y4));

    fir_tc_top #(.DATA_W(DW), .COEF_W(CW), .N_TAPS(N10), .COEF(C10)) dut10 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .x_i(x_i),
        .out_valid(v10), .y_o(y10));

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int k = 0; k < N4; k++) h4[k] = 0;
        for (int k = 0; k < N10; k++) h10[k] = 0;
        e4 = 0;
        e10 = 0;
    endtask

    task automatic push(input int xv, input string tag);
        for (int k = N4 - 1; k > 0; k--) h4[k] = h4[k-1];
        for (int k = N10 - 1; k > 0; k--) h10[k] = h10[k-1];
        h4[0] = xv;
        h10[0] = xv;
        e4 = 0;
        e10 = 0;
        for (int k = 0; k < N4; k++) e4 += C4[k] * h4[k];
        for (int k = 0; k < N10; k++) e10 += C10[k] * h10[k];
        x_i = DW'(xv);
        in_valid = 1'b1;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        check({tag, " 4-tap y"}, int'(y4), e4);
        check({tag, " R8 10-tap y"}, int'(y10), e10);
        check({tag, " R5 out_valid"}, int'(v4 & v10), 1);
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        x_i = 8'sd99;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            check("R5 idle out_valid low", int'(v4 | v10), 0);
            check("R4 idle hold 4-tap", int'(y4), e4);
            check("R4 idle hold 10-tap", int'(y10), e10);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        clear_model();
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        check("R6 reset y 4-tap", int'(y4), 0);
        check("R6 reset y 10-tap", int'(y10), 0);
        check("R6 reset out_valid", int'(v4 | v10), 0);

        // table walk: impulse exercises R3 sign flags, alternating exercises R7
        for (int i = 0; i < NSTIM; i++) begin
            if (i < 10)      push(STIM[i], "R1 R3 impulse");
            else if (i < 20) push(STIM[i], "R1 step");
            else             push(STIM[i], "R1 R7 full-scale");
        end

        // gaps must not insert zeros into the history
        idle(3);
        push(-128, "R4 after gap");
        push(127, "R4 after gap");
        idle(1);
        push(-128, "R7 extreme after gap");

        // random with sporadic gaps, product exactness through the output
        for (int i = 0; i < 300; i++) begin
            push(int'($urandom_range(0, 255)) - 128, "R1 R2 random");
            if (($urandom_range(0, 7)) == 0) idle(1);
        end

        // mid-stream reset clears history
        rst = 1'b1;
        in_valid = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0;
        in_valid = 1'b0;
        clear_model();
        check("R6 mid reset y 4-tap", int'(y4), 0);
        check("R6 mid reset y 10-tap", int'(y10), 0);
        check("R6 mid reset out_valid", int'(v4 | v10), 0);
        push(-1, "R6 R3 impulse after reset");
        for (int i = 0; i < 10; i++) push(0, "R6 R3 impulse after reset");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule